// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses of one SDRAM read or write burst, one column per clock. A one-cycle start pulse loads a start column along with a burst length code and an order select. From the next clock the block presents the columns of the burst in sequence on `col_o`, with `valid_o` high, and marks the final beat with `last_o`. A memory controller places these columns on its command bus, so row and bank handling stay outside this block.

Finite bursts of 2, 4 or 8 beats stay inside the aligned block of columns that holds the start column. The order within that block is either a wrapping count or an XOR pattern. A full-page burst walks every column of the row, wrapping past the top. It runs until a stop request arrives or a new start replaces it. A start pulse is accepted in any cycle, including in the middle of a burst, and the new sequence begins on the next clock.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: When `start_i` is high at a rising edge, the next cycle shows `valid_o`=1 and `col_o` equal to the sampled `start_col_i`. This is beat 0.
- R3: `len_i` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and codes 4 to 7 give full page. A finite burst of N beats keeps `valid_o` high for exactly N consecutive cycles and then drops it, unless a new start arrives.
- R4: With `ilv_i`=0 and a finite length N, beat k shows the start column with its low log2(N) bits replaced by the low log2(N) bits of (start + k). The upper bits do not change.
- R5: With `ilv_i`=1 and a length of 2, 4 or 8, beat k shows the start column with its low log2(N) bits XORed with k.
- R6: For a finite burst, `last_o` is 1 on the final beat only. `last_o` is never 1 while `valid_o` is 0.
- R7: In full-page mode, each beat shows the previous column plus one, wrapping from the top column (255 at the default width) to 0. `last_o` stays 0 and the burst continues until it is stopped or restarted.
- R8: `ilv_i` has no effect in full-page mode, where the order is always linear. Length 1 gives a single beat with `last_o`=1.
- R9: When `stop_i` is high at a rising edge during a burst, and `start_i` is low, `valid_o` and `last_o` are 0 from the next cycle. No further beats of that burst appear.
- R10: A start pulse during a burst discards the old sequence. The next cycle shows beat 0 of the new burst. When `start_i` and `stop_i` are high together, the start takes priority.
- R11: `start_col_i`, `len_i` and `ilv_i` are sampled only on a start pulse. Changing them during a burst does not alter its columns, its length or its order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse that loads a new burst |
| start_col_i | input | COL_W | Start column, sampled on the start pulse |
| len_i | input | 3 | Burst length code (see R3) |
| ilv_i | input | 1 | Order select: 0 linear, 1 interleaved |
| stop_i | input | 1 | Request to end the burst that is running |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | The current beat is valid |
| last_o | output | 1 | The current beat is the final beat of a finite burst |

## Verification
All three outputs are registered, so every result is due one clock after the edge that samples its cause. Beat 0 follows the start edge by one cycle and beat k follows it by k+1 cycles. The cycle after a stop or a final beat shows `valid_o` low. The bench drives inputs on falling edges and samples one falling edge after each relevant rising edge, so each check reads exactly the cycle the requirement names. The restart and stop scenarios insert their pulse at a chosen beat, and the next sample must already show the new beat 0 or an idle output.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

  localparam int LEN_CODE_W = 3;
  localparam int LG_W       = 2;

  // Length codes on the len input
  typedef enum logic [LEN_CODE_W-1:0] {
    BLEN_1    = 3'd0,
    BLEN_2    = 3'd1,
    BLEN_4    = 3'd2,
    BLEN_8    = 3'd3,
    BLEN_PAGE = 3'd4
  } blen_e;

  // Decoded burst mode held for the duration of a burst
  typedef struct packed {
    logic            page;  // full-page, unbounded
    logic            xorp;  // interleaved order in effect
    logic [LG_W-1:0] lg;    // log2 of finite length
  } bmode_t;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import sdram_burst_pkg::*;
(
  input  logic [LEN_CODE_W-1:0] code_i,
  input  logic                  ilv_i,
  output bmode_t                mode_o
);

  logic page;

  always_comb begin
    page        = (code_i >= LEN_CODE_W'(BLEN_PAGE));
    mode_o.page = page;
    mode_o.lg   = page ? '0 : code_i[LG_W-1:0];
    mode_o.xorp = ilv_i && !page && (code_i[LG_W-1:0] != '0);
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  bmode_t           mode_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] sum_col;
  logic [COL_W-1:0] xor_col;

  // Bits that move during the burst; the rest keep the start column
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign wrap_mask[b] = mode_i.page || (b < int'(mode_i.lg));
  end

  always_comb begin
    sum_col = base_i + idx_i;
    xor_col = base_i ^ idx_i;
    if (mode_i.xorp)
      col_o = (base_i & ~wrap_mask) | (xor_col & wrap_mask);
    else
      col_o = (base_i & ~wrap_mask) | (sum_col & wrap_mask);
  end

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  bmode_t           mode_new_i,
  input  bmode_t           mode_cur_i,
  output logic             valid_o,
  output logic             last_o,
  output logic             adv_o,
  output logic [COL_W-1:0] idx_nxt_o
);

  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] final_idx;
  logic             last_nxt;

  always_comb begin
    idx_nxt_o = idx_q + COL_W'(1);
    final_idx = COL_W'((32'd1 << mode_cur_i.lg) - 32'd1);
    last_nxt  = !mode_cur_i.page && (idx_nxt_o == final_idx);
    adv_o     = valid_o && !start_i && !stop_i && !last_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (start_i) begin
      idx_q   <= '0;
      valid_o <= 1'b1;
      last_o  <= !mode_new_i.page && (mode_new_i.lg == '0);
    end else if (adv_o) begin
      idx_q   <= idx_nxt_o;
      last_o  <= last_nxt;
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_i,
  input  logic                  ilv_i,
  input  logic                  stop_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  last_o
);

  bmode_t           mode_new;
  bmode_t           mode_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] idx_nxt;
  logic [COL_W-1:0] col_nxt;
  logic             adv;

  burst_len_decode u_dec (
    .code_i (len_i),
    .ilv_i  (ilv_i),
    .mode_o (mode_new)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .mode_new_i (mode_new),
    .mode_cur_i (mode_q),
    .valid_o    (valid_o),
    .last_o     (last_o),
    .adv_o      (adv),
    .idx_nxt_o  (idx_nxt)
  );

  burst_col_gen #(.COL_W(COL_W)) u_gen (
    .base_i (base_q),
    .idx_i  (idx_nxt),
    .mode_i (mode_q),
    .col_o  (col_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mode_q <= '0;
      col_o  <= '0;
    end else if (start_i) begin
      base_q <= start_col_i;
      mode_q <= mode_new;
      col_o  <= start_col_i;
    end else if (adv) begin
      col_o  <= col_nxt;
    end
  end

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start_i,
  input logic [COL_W-1:0]      start_col_i,
  input logic [LEN_CODE_W-1:0] len_i,
  input logic                  ilv_i,
  input logic                  stop_i,
  input logic [COL_W-1:0]      col_o,
  input logic                  valid_o,
  input logic                  last_o
);

  logic             page_q;
  logic [COL_W-1:0] mask_q;

  // Shadow of the length in force, taken from the ports
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= 1'b0;
      mask_q <= '0;
    end else if (start_i) begin
      page_q <= (len_i >= 3'd4);
      mask_q <= (len_i >= 3'd4) ? '1 : COL_W'((32'd1 << len_i[1:0]) - 32'd1);
    end
  end

  assert_last_in_burst_R6: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> valid_o && (col_o == $past(start_col_i)));

  assert_stop_ends_R9: assert property (@(posedge clk) disable iff (rst)
    valid_o && stop_i && !start_i |=> !valid_o && !last_o);

  assert_final_beat_ends_R3: assert property (@(posedge clk) disable iff (rst)
    valid_o && last_o && !start_i |=> !valid_o);

  assert_page_never_last_R7: assert property (@(posedge clk) disable iff (rst)
    valid_o && page_q |-> !last_o);

  assert_page_steps_R7: assert property (@(posedge clk) disable iff (rst)
    valid_o && page_q && !start_i && !stop_i
      |=> valid_o && (col_o == COL_W'($past(col_o) + COL_W'(1))));

  assert_block_kept_R4: assert property (@(posedge clk) disable iff (rst)
    valid_o && !page_q && !last_o && !start_i && !stop_i
      |=> valid_o && ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)));

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .len_i       (len_i),
  .ilv_i       (ilv_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_i = '0;
  logic       ilv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o;
  logic       last_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(8)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .len_i(len_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int beats_of(input logic [2:0] code);
    return (code >= 3'd4) ? 0 : (1 << code[1:0]);
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] b, input logic [2:0] code,
                                         input logic ilv, input int k);
    logic [7:0] m;
    logic [7:0] kk;
    kk = 8'(k);
    if (code >= 3'd4) return b + kk;
    m = 8'((1 << code[1:0]) - 1);
    if (ilv) return (b & ~m) | ((b ^ kk) & m);
    return (b & ~m) | ((b + kk) & m);
  endfunction

  task automatic pulse_start(input logic [7:0] b, input logic [2:0] code, input logic ilv);
    start_i = 1'b1; start_col_i = b; len_i = code; ilv_i = ilv;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    chk("R1", "valid in reset", int'(valid_o), 0);
    chk("R1", "last in reset", int'(last_o), 0);
    chk("R1", "col in reset", int'(col_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "valid after reset", int'(valid_o), 0);
    chk("R1", "col after reset", int'(col_o), 0);
  endtask

  // R2 R3 R4 R5 R6 R8 R11
  task automatic t_burst(input logic [7:0] b, input logic [2:0] code, input logic ilv,
                         input bit scramble, input string req);
    int n;
    n = beats_of(code);
    pulse_start(b, code, ilv);
    if (scramble) begin
      start_col_i = ~b; len_i = (code == 3'd3) ? 3'd0 : 3'd3; ilv_i = ~ilv;
    end
    for (int k = 0; k < n; k++) begin
      chk(k == 0 ? "R2" : req, "valid", int'(valid_o), 1);
      chk(req, $sformatf("col beat %0d", k), int'(col_o), int'(exp_col(b, code, ilv && n > 1, k)));
      chk("R6", $sformatf("last beat %0d", k), int'(last_o), int'(k == n - 1));
      @(negedge clk);
    end
    chk("R3", "valid after final beat", int'(valid_o), 0);
    chk("R6", "last after final beat", int'(last_o), 0);
  endtask

  // R7 R8 R9
  task automatic t_page(input logic [7:0] b, input logic [2:0] code, input logic ilv, input int beats);
    pulse_start(b, code, ilv);
    for (int k = 0; k < beats; k++) begin
      chk("R7", "valid page", int'(valid_o), 1);
      chk(ilv ? "R8" : "R7", $sformatf("page col %0d", k), int'(col_o), int'(8'(b + 8'(k))));
      chk("R7", "page last", int'(last_o), 0);
      if (k == beats - 1) stop_i = 1'b1;
      @(negedge clk);
    end
    stop_i = 1'b0;
    chk("R9", "valid after page stop", int'(valid_o), 0);
    @(negedge clk);
    chk("R9", "still idle", int'(valid_o), 0);
  endtask

  // R9
  task automatic t_stop(input logic [7:0] b, input logic [2:0] code, input int at);
    pulse_start(b, code, 1'b0);
    for (int k = 0; k < at; k++) @(negedge clk);
    chk("R9", "col before stop", int'(col_o), int'(exp_col(b, code, 1'b0, at)));
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk("R9", "valid after stop", int'(valid_o), 0);
    chk("R9", "last after stop", int'(last_o), 0);
    @(negedge clk);
    chk("R9", "no beat resumes", int'(valid_o), 0);
  endtask

  // R10
  task automatic t_restart(input bit with_stop);
    pulse_start(8'h40, 3'd3, 1'b0);
    @(negedge clk); @(negedge clk);
    start_i = 1'b1; start_col_i = 8'h9D; len_i = 3'd2; ilv_i = 1'b1; stop_i = with_stop;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R10", "valid restart", int'(valid_o), 1);
      chk("R10", $sformatf("restart col %0d", k), int'(col_o), int'(exp_col(8'h9D, 3'd2, 1'b1, k)));
      chk("R10", "restart last", int'(last_o), int'(k == 3));
      @(negedge clk);
    end
    chk("R10", "idle after new burst", int'(valid_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_burst(8'h2D, 3'd0, 1'b0, 1'b0, "R8");
    t_burst(8'h2D, 3'd1, 1'b0, 1'b0, "R4");
    t_burst(8'h2D, 3'd2, 1'b0, 1'b0, "R4");
    t_burst(8'h2E, 3'd3, 1'b0, 1'b0, "R4");
    t_burst(8'h2D, 3'd1, 1'b1, 1'b0, "R5");
    t_burst(8'h2E, 3'd2, 1'b1, 1'b0, "R5");
    t_burst(8'h75, 3'd3, 1'b1, 1'b0, "R5");
    t_burst(8'hFB, 3'd3, 1'b0, 1'b1, "R11");
    t_burst(8'h13, 3'd2, 1'b1, 1'b1, "R11");
    t_page(8'hF9, 3'd4, 1'b0, 12);
    t_page(8'hFE, 3'd7, 1'b1, 6);
    t_stop(8'h58, 3'd3, 2);
    t_stop(8'h10, 3'd2, 0);
    t_restart(1'b0);
    t_restart(1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule